// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns one parallel character into a serial frame on a single output line that rests high between frames. The frame shape is chosen at run time through three small configuration fields: how many data bits the character carries (five to eight), which of five parity policies applies, and how long the closing high period lasts (one, one and a half, or two bit times). A divisor input gives the length of one bit time in system clock cycles.

A one-entry holding register sits in front of the shift engine. A producer offers a character with a one-cycle strobe. While the holding register is free, the character is taken. The engine then pulls it in as soon as it is idle, or at the very end of the frame in flight, so consecutive frames follow each other with no idle gap. Two status outputs tell the producer when the holding register can take another character and when the line has gone quiet after the last frame.

Top module: `serial_frame_tx`

## Requirements
- R1: After reset, and whenever no frame is in flight, `line_out` is 1, `dr_empty` is 1 and `tx_done` is 1.
- R2: A frame is a low start bit, then the data bits least significant first, then the parity bit if one is enabled, then the high stop period. Every start, data and parity bit lasts exactly `divisor` clock cycles (`divisor` must be at least 2).
- R3: `cfg_len` selects the character length as 5 + `cfg_len` data bits (0 gives 5, 3 gives 8). Bits of `wr_data` above that length are not sent and do not affect parity.
- R4: `cfg_par` selects the parity bit: 0 means no parity bit, 1 means even (the ones in data plus parity form an even count), 2 means odd (an odd count), 3 means a constant 0, 4 means a constant 1. The values 5 to 7 behave as 0.
- R5: `cfg_stop` sets the stop period: 0 gives `divisor` cycles, 1 gives `divisor` + floor(`divisor`/2) cycles, and 2 or 3 give 2·`divisor` cycles.
- R6: A write is accepted on the clock edge that samples `wr_valid` high while `dr_empty` is 1. When the engine is idle, the start bit begins on the following clock edge.
- R7: `dr_empty` falls on the edge that accepts a write and stays low until the engine takes the held character. A write presented while `dr_empty` is 0 is ignored.
- R8: `tx_done` falls on the edge that accepts a write. It rises at the end of a stop period only if no character is held. When a character is held at that point, its start bit follows the stop period directly, and `tx_done` stays low.
- R9: The configuration fields and `divisor` are used as they stand when the engine takes a character. Changing them during a frame does not alter the frame in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | One-cycle strobe offering `wr_data` |
| wr_data | input | DATA_W | Character to send |
| cfg_len | input | 2 | Character length code, 5 + value bits |
| cfg_par | input | 3 | Parity policy code |
| cfg_stop | input | 2 | Stop period code |
| divisor | input | DIV_W | Clock cycles per bit time |
| line_out | output | 1 | Serial line, high when idle |
| dr_empty | output | 1 | Holding register can accept a character |
| tx_done | output | 1 | Line quiet, no frame in flight or waiting |

## Verification
A wrong bit counter or a wrong parity latch shows on `line_out` within the frame it corrupts. The damage is seen at the centre of the first misplaced bit, or as a stop period whose length is wrong, which is found by counting cycles to the next start bit or to the rise of `tx_done`. A holding register that is lost, duplicated or overwritten shows as a missing frame, a repeated frame or a frame carrying the character that should have been ignored. It also shows as `dr_empty` or `tx_done` out of step with the frame boundaries, which is visible within one clock of the boundary.

// File: rtl/sftx_pkg.sv
package sftx_pkg;

  localparam int MIN_CHAR_BITS = 5;

  typedef enum logic [2:0] {
    PAR_NONE  = 3'd0,
    PAR_EVEN  = 3'd1,
    PAR_ODD   = 3'd2,
    PAR_SPACE = 3'd3,
    PAR_MARK  = 3'd4
  } par_mode_e;

  typedef enum logic [1:0] {
    STOP_ONE      = 2'd0,
    STOP_ONE_HALF = 2'd1,
    STOP_TWO      = 2'd2
  } stop_mode_e;

  typedef enum logic [2:0] {
    S_IDLE   = 3'd0,
    S_START  = 3'd1,
    S_DATA   = 3'd2,
    S_PARITY = 3'd3,
    S_STOP1  = 3'd4,
    S_STOP2  = 3'd5
  } tx_state_e;

endpackage

// File: rtl/sftx_hold.sv
module sftx_hold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic [DW-1:0] wr_data,
  input  logic          take,
  output logic          accept,
  output logic          full,
  output logic [DW-1:0] data
);

  logic          full_q, full_d;
  logic [DW-1:0] data_q;

  assign accept = wr_valid & ~full_q;

  always_comb begin
    full_d = full_q;
    if (take)        full_d = 1'b0;
    else if (accept) full_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
    end else begin
      full_q <= full_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (accept) begin
      data_q <= wr_data;
    end
  end

  assign full = full_q;
  assign data = data_q;

endmodule

// File: rtl/sftx_bit_timer.sv
module sftx_bit_timer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          tick
);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)              cnt_d = load_val;
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign tick = (cnt_q == '0);

endmodule

// File: rtl/sftx_shifter.sv
module sftx_shifter
  import sftx_pkg::*;
#(
  parameter int DW = 8,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold_full,
  input  logic [DW-1:0] hold_data,
  input  logic          wr_accept,
  input  logic [1:0]    cfg_len,
  input  logic [2:0]    cfg_par,
  input  logic [1:0]    cfg_stop,
  input  logic [CW-1:0] divisor,
  input  logic          tick,
  output logic          take,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_val,
  output logic          line,
  output logic          done
);

  localparam int BW = (DW > 1) ? $clog2(DW) : 1;

  tx_state_e      state_q, state_d;
  logic [DW-1:0]  sh_q, sh_d;
  logic [BW-1:0]  left_q, left_d;
  logic [BW-1:0]  last_idx_q, last_idx_d;
  logic           par_q, par_d;
  logic           has_par_q, has_par_d;
  logic [1:0]     stop_q, stop_d;
  logic [CW-1:0]  div_q, div_d;
  logic           done_q, done_d;

  logic [DW-1:0]  len_mask;
  logic           new_par_bit;
  logic           new_has_par;
  logic           stop_is_one;
  logic           frame_end;
  logic [CW-1:0]  bit_len_m1;
  logic [CW-1:0]  half_len_m1;

  // Mask of the bits belonging to the selected character length.
  always_comb begin
    for (int i = 0; i < DW; i++) begin
      len_mask[i] = (i < (MIN_CHAR_BITS + int'(cfg_len)));
    end
  end

  always_comb begin
    new_has_par = 1'b1;
    new_par_bit = 1'b0;
    case (par_mode_e'(cfg_par))
      PAR_EVEN:  new_par_bit = ^(hold_data & len_mask);
      PAR_ODD:   new_par_bit = ~^(hold_data & len_mask);
      PAR_SPACE: new_par_bit = 1'b0;
      PAR_MARK:  new_par_bit = 1'b1;
      default:   new_has_par = 1'b0;
    endcase
  end

  assign stop_is_one = (stop_q == STOP_ONE);
  assign bit_len_m1  = div_q - 1'b1;
  assign half_len_m1 = (div_q >> 1) - 1'b1;
  assign frame_end   = tick && ((state_q == S_STOP1 && stop_is_one) || state_q == S_STOP2);
  assign take        = hold_full && (state_q == S_IDLE || frame_end);

  always_comb begin
    state_d    = state_q;
    sh_d       = sh_q;
    left_d     = left_q;
    last_idx_d = last_idx_q;
    par_d      = par_q;
    has_par_d  = has_par_q;
    stop_d     = stop_q;
    div_d      = div_q;
    done_d     = done_q;
    tmr_load   = 1'b0;
    tmr_val    = bit_len_m1;

    if (wr_accept) done_d = 1'b0;

    if (take) begin
      state_d    = S_START;
      sh_d       = hold_data;
      last_idx_d = BW'(MIN_CHAR_BITS - 1) + BW'(cfg_len);
      par_d      = new_par_bit;
      has_par_d  = new_has_par;
      stop_d     = cfg_stop;
      div_d      = divisor;
      tmr_load   = 1'b1;
      tmr_val    = divisor - 1'b1;
    end else if (tick && state_q != S_IDLE) begin
      case (state_q)
        S_START: begin
          state_d  = S_DATA;
          left_d   = last_idx_q;
          tmr_load = 1'b1;
        end
        S_DATA: begin
          tmr_load = 1'b1;
          if (left_q == '0) begin
            state_d = has_par_q ? S_PARITY : S_STOP1;
          end else begin
            sh_d   = sh_q >> 1;
            left_d = left_q - 1'b1;
          end
        end
        S_PARITY: begin
          state_d  = S_STOP1;
          tmr_load = 1'b1;
        end
        S_STOP1: begin
          if (stop_is_one) begin
            state_d = S_IDLE;
            if (!wr_accept) done_d = 1'b1;
          end else begin
            state_d  = S_STOP2;
            tmr_load = 1'b1;
            tmr_val  = (stop_q == STOP_ONE_HALF) ? half_len_m1 : bit_len_m1;
          end
        end
        S_STOP2: begin
          state_d = S_IDLE;
          if (!wr_accept) done_d = 1'b1;
        end
        default: state_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      sh_q       <= '0;
      left_q     <= '0;
      last_idx_q <= '0;
      par_q      <= 1'b0;
      has_par_q  <= 1'b0;
      stop_q     <= '0;
      div_q      <= '0;
      done_q     <= 1'b1;
    end else begin
      state_q    <= state_d;
      sh_q       <= sh_d;
      left_q     <= left_d;
      last_idx_q <= last_idx_d;
      par_q      <= par_d;
      has_par_q  <= has_par_d;
      stop_q     <= stop_d;
      div_q      <= div_d;
      done_q     <= done_d;
    end
  end

  always_comb begin
    case (state_q)
      S_START:  line = 1'b0;
      S_DATA:   line = sh_q[0];
      S_PARITY: line = par_q;
      default:  line = 1'b1;
    endcase
  end

  assign done = done_q;

endmodule

// File: rtl/serial_frame_tx.sv
module serial_frame_tx #(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        cfg_len,
  input  logic [2:0]        cfg_par,
  input  logic [1:0]        cfg_stop,
  input  logic [DIV_W-1:0]  divisor,
  output logic              line_out,
  output logic              dr_empty,
  output logic              tx_done
);

  logic              hold_full;
  logic [DATA_W-1:0] hold_data;
  logic              wr_accept;
  logic              take;
  logic              tmr_load;
  logic [DIV_W-1:0]  tmr_val;
  logic              tick;

  sftx_hold #(.DW(DATA_W)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (wr_valid),
    .wr_data  (wr_data),
    .take     (take),
    .accept   (wr_accept),
    .full     (hold_full),
    .data     (hold_data)
  );

  sftx_bit_timer #(.CW(DIV_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .tick     (tick)
  );

  sftx_shifter #(.DW(DATA_W), .CW(DIV_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold_full (hold_full),
    .hold_data (hold_data),
    .wr_accept (wr_accept),
    .cfg_len   (cfg_len),
    .cfg_par   (cfg_par),
    .cfg_stop  (cfg_stop),
    .divisor   (divisor),
    .tick      (tick),
    .take      (take),
    .tmr_load  (tmr_load),
    .tmr_val   (tmr_val),
    .line      (line_out),
    .done      (tx_done)
  );

  assign dr_empty = ~hold_full;

endmodule

// File: rtl/serial_frame_tx_chk.sv
module serial_frame_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_valid,
  input logic line_out,
  input logic dr_empty,
  input logic tx_done
);

  AST_DONE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> line_out);  // R1

  AST_DONE_NOTHING_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> dr_empty);  // R8

  AST_WRITE_FILLS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && dr_empty) |=> !dr_empty);  // R7

  AST_WRITE_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && dr_empty) |=> !tx_done);  // R8

  AST_TAKE_STARTS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dr_empty) |-> !line_out);  // R6

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done && !wr_valid) |=> tx_done);  // R8

endmodule

bind serial_frame_tx serial_frame_tx_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_valid (wr_valid),
  .line_out (line_out),
  .dr_empty (dr_empty),
  .tx_done  (tx_done)
);

// File: tb/serial_frame_tx_tb.sv
module serial_frame_tx_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_valid;
  logic [7:0]  wr_data;
  logic [1:0]  cfg_len;
  logic [2:0]  cfg_par;
  logic [1:0]  cfg_stop;
  logic [15:0] divisor;
  logic        line_out, dr_empty, tx_done;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;  // 125 MHz

  serial_frame_tx u_dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .cfg_len(cfg_len), .cfg_par(cfg_par), .cfg_stop(cfg_stop),
    .divisor(divisor), .line_out(line_out), .dr_empty(dr_empty), .tx_done(tx_done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int nbits_of(input logic [1:0] len);
    return 5 + int'(len);
  endfunction

  function automatic logic [7:0] mask_of(input logic [1:0] len);
    return 8'hFF >> (3 - int'(len));
  endfunction

  function automatic bit has_par_of(input logic [2:0] par);
    return (par >= 3'd1 && par <= 3'd4);
  endfunction

  function automatic logic par_of(input logic [7:0] d, input logic [1:0] len, input logic [2:0] par);
    logic [7:0] m;
    m = d & mask_of(len);
    case (par)
      3'd1: return ^m;
      3'd2: return ~^m;
      3'd4: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic int stop_of(input logic [1:0] st, input int d);
    case (st)
      2'd0: return d;
      2'd1: return d + d / 2;
      default: return 2 * d;
    endcase
  endfunction

  // Capture one frame, starting from the first cycle the line is low.
  task automatic rx_frame(input int nb, input bit hp, input int d,
                          output logic st, output logic [7:0] data,
                          output logic pb, output int stopc);
    int guard = 0;
    while (line_out !== 1'b0 && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    repeat (d / 2) @(negedge clk);
    st = line_out;
    data = '0;
    for (int i = 0; i < nb; i++) begin
      repeat (d) @(negedge clk);
      data[i] = line_out;
    end
    pb = 1'b0;
    if (hp) begin
      repeat (d) @(negedge clk);
      pb = line_out;
    end
    repeat (d - d / 2) @(negedge clk);
    stopc = 0;
    while (line_out === 1'b1 && tx_done !== 1'b1 && stopc < 5000) begin
      stopc++;
      @(negedge clk);
    end
  endtask

  task automatic send_check(input logic [7:0] d8, input logic [1:0] len,
                            input logic [2:0] par, input logic [1:0] st, input int d,
                            input bit cfg_flip);
    logic s, pb;
    logic [7:0] got;
    int sc;
    cfg_len = len; cfg_par = par; cfg_stop = st; divisor = 16'(d);
    wr_data = d8; wr_valid = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0;
    chk(dr_empty == 1'b0, "R7 empty falls on write", int'(dr_empty), 0);
    chk(tx_done == 1'b0, "R8 done clears on write", int'(tx_done), 0);
    chk(line_out == 1'b1, "R6 line still high", int'(line_out), 1);
    @(negedge clk);
    chk(line_out == 1'b0, "R6 start bit next edge", int'(line_out), 0);
    chk(dr_empty == 1'b1, "R7 empty after take", int'(dr_empty), 1);
    if (cfg_flip) begin
      cfg_len = ~len; cfg_par = 3'(par + 3'd1); cfg_stop = ~st; divisor = 16'(d + 3);
    end
    rx_frame(nbits_of(len), has_par_of(par), d, s, got, pb, sc);
    chk(s == 1'b0, "R2 start bit low", int'(s), 0);
    chk(got == (d8 & mask_of(len)), "R2 R3 data bits", int'(got), int'(d8 & mask_of(len)));
    if (has_par_of(par))
      chk(pb == par_of(d8, len, par), "R4 parity bit", int'(pb), int'(par_of(d8, len, par)));
    chk(sc == stop_of(st, d), cfg_flip ? "R9 stop length" : "R5 stop length", sc, stop_of(st, d));
    chk(tx_done == 1'b1 && line_out == 1'b1, "R8 done at stop end", int'(tx_done), 1);
    chk(dr_empty == 1'b1, "R1 idle empty", int'(dr_empty), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual 0 expected 1 (run ended)");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd7331));
    rst_n = 1'b0; wr_valid = 1'b0; wr_data = '0;
    cfg_len = 2'd3; cfg_par = 3'd0; cfg_stop = 2'd0; divisor = 16'd4;
    repeat (4) @(negedge clk);
    chk(line_out && dr_empty && tx_done, "R1 reset state", int'({line_out, dr_empty, tx_done}), 7);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(line_out && dr_empty && tx_done, "R1 idle after reset", int'({line_out, dr_empty, tx_done}), 7);

    // Directed corner cases
    send_check(8'hA5, 2'd3, 3'd0, 2'd0, 4, 1'b0);   // R2 plain 8N1
    send_check(8'hFF, 2'd0, 3'd4, 2'd2, 3, 1'b0);   // R3 5 bits, mark, two stops
    send_check(8'h00, 2'd1, 3'd2, 2'd1, 2, 1'b0);   // R4 odd on zero, R5 1.5 at minimum divisor
    send_check(8'hE7, 2'd2, 3'd1, 2'd1, 7, 1'b0);   // R4 even, R5 odd divisor 1.5
    send_check(8'h3C, 2'd2, 3'd3, 2'd3, 5, 1'b0);   // R4 space, R5 code 3
    send_check(8'h81, 2'd3, 3'd6, 2'd0, 3, 1'b0);   // R4 reserved code acts as none
    send_check(8'h5A, 2'd3, 3'd1, 2'd2, 4, 1'b1);   // R9 config change mid-frame

    // R7 R8: back-to-back frames and an ignored third write
    begin
      logic s, pb;
      logic [7:0] ga, gb;
      int sa, sb;
      bit seen_low;
      cfg_len = 2'd3; cfg_par = 3'd0; cfg_stop = 2'd0; divisor = 16'd4;
      fork
        begin
          wr_data = 8'h4B; wr_valid = 1'b1;
          @(negedge clk); wr_valid = 1'b0;
          @(negedge clk); wr_data = 8'hD2; wr_valid = 1'b1;
          @(negedge clk); wr_data = 8'h19; wr_valid = 1'b1;
          chk(dr_empty == 1'b0, "R7 held while second pending", int'(dr_empty), 0);
          @(negedge clk); wr_valid = 1'b0;
          repeat (4) @(negedge clk);
          chk(dr_empty == 1'b0, "R7 stays low until take", int'(dr_empty), 0);
        end
        begin
          rx_frame(8, 1'b0, 4, s, ga, pb, sa);
          chk(ga == 8'h4B, "R7 first frame data", int'(ga), 'h4B);
          chk(sa == 4 && tx_done == 1'b0, "R8 no gap, done low", sa, 4);
          rx_frame(8, 1'b0, 4, s, gb, pb, sb);
          chk(gb == 8'hD2, "R7 ignored write not sent", int'(gb), 'hD2);
          chk(tx_done == 1'b1, "R8 done after last frame", int'(tx_done), 1);
        end
      join
      seen_low = 1'b0;
      repeat (40) begin
        @(negedge clk);
        if (!line_out || !tx_done) seen_low = 1'b1;
      end
      chk(!seen_low, "R7 no third frame", int'(seen_low), 0);
    end

    // Constrained random frames
    for (int n = 0; n < 30; n++) begin
      logic [7:0] rd;
      logic [1:0] rl, rs;
      logic [2:0] rp;
      int rdv;
      rd  = 8'($urandom);
      rl  = 2'($urandom_range(3, 0));
      rp  = 3'($urandom_range(4, 0));
      rs  = 2'($urandom_range(2, 0));
      rdv = int'($urandom_range(8, 2));
      send_check(rd, rl, rp, rs, rdv, 1'b0);  // R2 R3 R4 R5 random
      repeat (int'($urandom_range(3, 0))) @(negedge clk);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule